// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Buffered Compare

The block is an 8-bit up-counter that advances only on a count enable ("tick"), never on every clock by default. The tick comes from one of three kinds of source. It can be the system clock itself. It can be one of four divided taps of a free-running prescaler. It can be an edge of an external pin, after that pin has been synchronised. A single register write port configures the block and also lets software load the counter, the compare value, the flag and the mask. The counter stops and holds its value when no source is chosen.

The counter climbs from BOTTOM (0x00) to TOP and then returns to BOTTOM on the next tick. Control bit 3 picks TOP. When bit 3 is 0 (free mode), TOP is MAX (0xFF). When bit 3 is 1 (compare-top mode), TOP is the active compare value. Software writes the compare value into a buffer. In free mode the active copy takes the new value at once. In compare-top mode the active copy takes it only on the tick at which the counter stands at TOP, so the period never changes in the middle of a cycle. On every tick the counter is compared with the active compare value. A match sets a sticky flag. The flag ANDed with a mask bit is the interrupt request.

The source selection is a small state machine whose state register holds the source. Its states are SRC_OFF (no ticks), SRC_DIV (system clock or a prescaler tap), SRC_FALL (external falling edge) and SRC_RISE (external rising edge). The only transition is a write to the control register. Such a write moves the machine from any state to the state that the 3-bit select code decodes to: 000 goes to SRC_OFF, 001 to 101 go to SRC_DIV, 110 goes to SRC_FALL and 111 goes to SRC_RISE. With no write, every state stays where it is.

Top module: `tmr8_top`

## Requirements
- R1: After reset the counter, active compare value, flag and interrupt request are all 0, and the source is SRC_OFF.
- R2: With select code 000 in control bits [2:0] (written at address 0), the counter holds its value on every clock.
- R3: Code 001 ticks on every clock. Codes 010, 011, 100 and 101 tick when the low 3, 6, 8 or 10 bits of a 10-bit prescaler are all ones. The prescaler is 0 at reset and increments on every clock, and a source change does not reset it.
- R4: Code 111 ticks once per rising edge and code 110 once per falling edge of the external pin. Each edge is seen through a two-flop synchroniser and an edge-history flop, so the count changes at the third clock edge after the pin changes. There is at most one tick per pin edge.
- R5: TOP is 0xFF when control bit 3 is 0 and the active compare value when bit 3 is 1. A tick while the counter equals TOP loads 0, and any other tick adds 1.
- R6: A write to address 1 loads the compare buffer. In free mode the active compare value loads the written value at the same clock edge. In compare-top mode the active value loads the buffer only on a tick at which the counter equals TOP.
- R7: A tick in a cycle where the counter equals the active compare value sets the flag at the following clock edge.
- R8: A write to address 3 with bit 0 set clears the flag, and a write with bit 0 clear leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R9: The interrupt request equals the flag ANDed with mask bit 0, written at address 4.
- R10: A write to address 2 loads the counter at that edge, and it overrides any tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External count input, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 compare, 2 counter, 3 flag, 4 mask |
| wr_data | input | 8 | Write data |
| cnt_o | output | 8 | Current counter value |
| cmp_act_o | output | 8 | Active compare value |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Two collisions are driven on purpose. In the first, a compare match that sets the flag falls in the same cycle as a software clear. The counter is loaded with the compare value while the block is stopped, the source is then started, and the clear is written in the first ticking cycle; the flag must come out set. In the second, a counter write lands on a cycle that ticks every clock; the counter must show the written value and not the value plus one. A behavioural model in the bench tracks every cycle and judges both cases, and directed checks with hand-computed values also cover each case.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_FALL = 2'd2,
        SRC_RISE = 2'd3
    } src_e;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_CMP  = 3'd1;
    localparam logic [2:0] ADR_CNT  = 3'd2;
    localparam logic [2:0] ADR_FLAG = 3'd3;
    localparam logic [2:0] ADR_MASK = 3'd4;

    localparam int NUM_TAPS = 4;

    function automatic int tap_bits(input int idx);
        case (idx)
            0:       tap_bits = 3;
            1:       tap_bits = 6;
            2:       tap_bits = 8;
            default: tap_bits = 10;
        endcase
    endfunction

    function automatic src_e decode_src(input logic [2:0] code);
        case (code)
            3'b000:  decode_src = SRC_OFF;
            3'b110:  decode_src = SRC_FALL;
            3'b111:  decode_src = SRC_RISE;
            default: decode_src = SRC_DIV;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
    parameter int PRE_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [tmr8_pkg::NUM_TAPS-1:0] tap_hit_o
);
    import tmr8_pkg::*;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int          BITS = tap_bits(g);
        localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << BITS) - 64'd1);
        assign tap_hit_o[g] = ((pre_q & MASK) == MASK);
    end

endmodule

// File: rtl/tmr8_clksel.sv
module tmr8_clksel #(
    parameter int PRE_W  = 10,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_code,
    input  logic       ext_pin,
    output logic       tick_o
);
    import tmr8_pkg::*;

    src_e       state_q;
    logic [2:0] code_q;
    logic [NUM_TAPS-1:0] tap_hit;
    logic [SYNC_N-1:0]   sync_q;
    logic                hist_q;
    logic                pin_s;
    logic                rise_hit;
    logic                fall_hit;

    tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap_hit_o (tap_hit)
    );

    // synchroniser chain plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ext_pin};
            hist_q <= sync_q[SYNC_N-1];
        end
    end

    assign pin_s    = sync_q[SYNC_N-1];
    assign rise_hit = pin_s & ~hist_q;
    assign fall_hit = ~pin_s & hist_q;

    // state register: source state changes only on a control write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_OFF;
            code_q  <= 3'b000;
        end else if (cfg_wr) begin
            state_q <= decode_src(cfg_code);
            code_q  <= cfg_code;
        end
    end

    // output process: tick from the current source state
    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            SRC_OFF:  tick_o = 1'b0;
            SRC_DIV: begin
                case (code_q)
                    3'b001:  tick_o = 1'b1;
                    3'b010:  tick_o = tap_hit[0];
                    3'b011:  tick_o = tap_hit[1];
                    3'b100:  tick_o = tap_hit[2];
                    3'b101:  tick_o = tap_hit[3];
                    default: tick_o = 1'b0;
                endcase
            end
            SRC_FALL: tick_o = fall_hit;
            SRC_RISE: tick_o = rise_hit;
        endcase
    end

    AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_OFF) |-> !tick_o); // R2

    AST_EXT_SINGLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (state_q == SRC_FALL || state_q == SRC_RISE) && !cfg_wr) |=> !tick_o); // R4

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cmp_act_o,
    output logic          flag_o,
    output logic          irq_o
);
    import tmr8_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] CNT_BOT = '0;

    logic [CW-1:0] cnt_q, buf_q, act_q;
    logic          top_mode_q, mask_q, flag_q;
    logic [CW-1:0] top_val;
    logic          at_top, hit, cnt_wr, cmp_wr, ctl_wr, flg_clr, msk_wr;

    assign cnt_wr  = wr_en && (wr_addr == ADR_CNT);
    assign cmp_wr  = wr_en && (wr_addr == ADR_CMP);
    assign ctl_wr  = wr_en && (wr_addr == ADR_CTRL);
    assign msk_wr  = wr_en && (wr_addr == ADR_MASK);
    assign flg_clr = wr_en && (wr_addr == ADR_FLAG) && wr_data[0];

    assign top_val = top_mode_q ? act_q : CNT_MAX;
    assign at_top  = (cnt_q == top_val);
    assign hit     = tick_i && (cnt_q == act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_mode_q <= 1'b0;
            mask_q     <= 1'b0;
        end else begin
            if (ctl_wr) top_mode_q <= wr_data[3];
            if (msk_wr) mask_q     <= wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= CNT_BOT;
        else if (cnt_wr) cnt_q <= wr_data;
        else if (tick_i) cnt_q <= at_top ? CNT_BOT : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (cmp_wr) buf_q <= wr_data;
            if (!top_mode_q)          act_q <= cmp_wr ? wr_data : buf_q;
            else if (tick_i && at_top) act_q <= buf_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;
        else if (flg_clr) flag_q <= 1'b0;
    end

    assign cnt_o     = cnt_q;
    assign cmp_act_o = act_q;
    assign flag_o    = flag_q;
    assign irq_o     = flag_q & mask_q;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr) |=> $stable(cnt_q)); // R2

    AST_WRAP_TO_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr && at_top) |=> (cnt_q == CNT_BOT)); // R5

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (cnt_q == act_q)) |=> flag_q); // R7

    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_clr && !tick_i) |=> !flag_q); // R8

    AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wr_data))); // R10

endmodule

// File: rtl/tmr8_top.sv
module tmr8_top #(
    parameter int CW     = 8,
    parameter int PRE_W  = 10,
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_pin,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cmp_act_o,
    output logic          flag_o,
    output logic          irq_o
);
    import tmr8_pkg::*;

    logic tick;
    logic cfg_wr;

    assign cfg_wr = wr_en && (wr_addr == ADR_CTRL);

    tmr8_clksel #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_clksel (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_code (wr_data[2:0]),
        .ext_pin  (ext_pin),
        .tick_o   (tick)
    );

    tmr8_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_o     (cnt_o),
        .cmp_act_o (cmp_act_o),
        .flag_o    (flag_o),
        .irq_o     (irq_o)
    );

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o); // R9

endmodule

// File: tb/tmr8_top_tb.sv
`timescale 1ns/1ps
module tmr8_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt_o, cmp_act_o;
    logic       flag_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr8_top u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .cmp_act_o(cmp_act_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    // behavioural reference model
    int m_pre, m_p1, m_p2, m_p3;
    int m_sel, m_topm, m_cnt, m_buf, m_act, m_flag, m_mask;

    always @(posedge clk or negedge rst_n) begin
        int t, topv, n_cnt, n_act, n_flag;
        if (!rst_n) begin
            m_pre = 0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
            m_sel = 0; m_topm = 0; m_cnt = 0; m_buf = 0; m_act = 0;
            m_flag = 0; m_mask = 0;
        end else begin
            case (m_sel)
                1: t = 1;
                2: t = (m_pre % 8) == 7;
                3: t = (m_pre % 64) == 63;
                4: t = (m_pre % 256) == 255;
                5: t = (m_pre % 1024) == 1023;
                6: t = (m_p3 == 1 && m_p2 == 0);
                7: t = (m_p2 == 1 && m_p3 == 0);
                default: t = 0;
            endcase
            topv = m_topm ? m_act : 255;
            n_cnt = m_cnt;
            if (wr_en && wr_addr == 2) n_cnt = wr_data;
            else if (t) n_cnt = (m_cnt == topv) ? 0 : m_cnt + 1;
            n_act = m_act;
            if (m_topm == 0) n_act = (wr_en && wr_addr == 1) ? int'(wr_data) : m_buf;
            else if (t && m_cnt == topv) n_act = m_buf;
            n_flag = m_flag;
            if (t && m_cnt == m_act) n_flag = 1;
            else if (wr_en && wr_addr == 3 && wr_data[0]) n_flag = 0;
            if (wr_en && wr_addr == 1) m_buf = wr_data;
            if (wr_en && wr_addr == 0) begin m_sel = wr_data[2:0]; m_topm = wr_data[3]; end
            if (wr_en && wr_addr == 4) m_mask = wr_data[0];
            m_cnt = n_cnt; m_act = n_act; m_flag = n_flag;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_pin;
            m_pre = (m_pre + 1) % 1024;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 R5 R10 counter", cnt_o, m_cnt);
            check("R6 active compare", cmp_act_o, m_act);
            check("R7 R8 flag", flag_o, m_flag);
            check("R9 irq", irq_o, m_flag & m_mask);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 counter", cnt_o, 0);
        check("R1 compare", cmp_act_o, 0);
        check("R1 flag", flag_o, 0);
        check("R1 irq", irq_o, 0);
        idle(5);
        check("R1 stopped", cnt_o, 0);

        // R3 every clock and R10 write beats tick
        wr(0, 8'h01);
        wr(2, 8'd100);
        check("R10 written value", cnt_o, 100);
        idle(5);
        check("R3 five ticks", cnt_o, 105);
        idle(300);
        wr(3, 8'h01);
        wr(4, 8'h01);
        idle(300);

        // R2 stop holds
        wr(0, 8'h00);
        held = cnt_o;
        idle(20);
        check("R2 hold", cnt_o, held);

        // R3 divided taps
        wr(0, 8'h02); idle(200);
        wr(0, 8'h03); idle(300);
        wr(0, 8'h04); idle(800);
        wr(0, 8'h05); idle(2100);

        // R6 free mode loads active at once
        wr(0, 8'h00);
        wr(1, 8'd10);
        check("R6 free immediate", cmp_act_o, 10);

        // R6 R5 compare-top mode
        wr(0, 8'h08);
        wr(1, 8'd5);
        check("R6 buffered hold", cmp_act_o, 10);
        wr(2, 8'd10);
        wr(0, 8'h09);
        @(negedge clk);
        check("R5 wrap to bottom", cnt_o, 0);
        check("R6 load at top", cmp_act_o, 5);
        idle(40);

        // R8 set and clear collide
        wr(0, 8'h08);
        wr(2, 8'd5);
        wr(3, 8'h01);
        check("R8 clear", flag_o, 0);
        wr(0, 8'h09);
        wr(3, 8'h01);
        check("R8 set wins", flag_o, 1);
        check("R7 wrap after match", cnt_o, 0);
        wr(0, 8'h08);

        // R9 mask
        wr(4, 8'h00);
        check("R9 masked", irq_o, 0);
        wr(4, 8'h01);
        check("R9 unmasked", irq_o, 1);
        wr(3, 8'h00);
        check("R8 zero write ignored", flag_o, 1);
        wr(3, 8'h01);
        check("R8 one clears", flag_o, 0);

        // R4 external edges
        wr(0, 8'h00);
        wr(2, 8'd32);
        wr(0, 8'h07);
        idle(4);
        check("R4 quiet pin", cnt_o, 32);
        ext_pin = 1'b1; idle(5);
        check("R4 rising counts", cnt_o, 33);
        ext_pin = 1'b0; idle(5);
        check("R4 falling ignored", cnt_o, 33);
        wr(0, 8'h06);
        ext_pin = 1'b1; idle(5);
        check("R4 rising ignored", cnt_o, 33);
        ext_pin = 1'b0; idle(5);
        check("R4 falling counts", cnt_o, 34);
        for (int i = 0; i < 40; i++) begin
            ext_pin = ~ext_pin;
            idle((i % 3) + 1);
        end
        wr(0, 8'h07);
        for (int i = 0; i < 40; i++) begin
            ext_pin = ~ext_pin;
            idle((i % 4) + 1);
        end
        wr(0, 8'h0F);
        for (int i = 0; i < 30; i++) begin
            ext_pin = ~ext_pin;
            idle(2);
        end
        idle(10);
        finish_run();
    end

endmodule